// File: doc/BRIEF.md
# Half-Band Polyphase Interpolator (x2)

This block doubles the sample rate of a stream of 16-bit signed samples. It applies a half-band anti-imaging low-pass filter, split into its two polyphase branches. Every accepted input sample produces two outputs. The first is the even phase, a symmetric FIR sum computed by one shared, pipelined multiply-accumulate unit. The second is the odd phase. In a half-band filter every odd-indexed tap is zero except the centre tap, which is exactly one half, so the odd phase is one stored sample shifted right by one bit.

Samples are kept in a circular history of NE = (NTAPS+1)/2 entries, where NTAPS = 4K+3 (for example 19 or 99). The write pointer moves forward by one for each accepted sample. Two read pointers start at the newest and the oldest entries and move toward each other, so the two samples that share a coefficient are added before the multiply. Only the NU = NE/2 distinct coefficients are stored. The same structure can serve several cascaded stages with different tap counts.

Control is a four-state machine:
- IDLE: ready for input. IDLE→MAC on an accepted sample.
- MAC: runs the NU pair reads plus two pipeline drain cycles. MAC→EVEN after cnt reaches NU+1.
- EVEN: presents the even phase. EVEN→ODD on out_ready.
- ODD: presents the odd phase. ODD→IDLE on out_ready.

Top module: `halfband_interp2`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and every history entry holds zero.
- R2: in_ready is high only in IDLE. A sample offered while the outputs of the previous sample are still pending is not taken and does not change any later output.
- R3: Each accepted sample yields exactly two outputs, in order. The even phase comes first and is flagged out_odd=0. The odd phase comes second and is flagged out_odd=1.
- R4: The even phase equals sat16(floor((A + 2^14) / 2^15)). A is the sum, over j = 0..NU-1, of c[j]·(x[n−j] + x[n−(NE−1−j)]), where x[n] is the newest sample.
- R5: Let d = NU−1−j. Coefficient c[j] has magnitude PEAK >> d and is positive when d is even, negative when d is odd. With the defaults, c = {1250, −2500, 5000, −10000, 20000} for j = 0..4.
- R6: The odd phase equals x[n−(NU−1)] shifted arithmetically right by one bit, which is floor division by 2.
- R7: Sample positions not yet written since reset count as zero in both phases.
- R8: The even phase becomes valid exactly NU+2 clock edges after the edge that accepts the sample.
- R9: An even-phase result above 32767 or below −32768 is clamped to that limit.
- R10: While out_valid is high and out_ready is low, out_data and out_odd hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | 16 | Signed output sample |
| out_odd | output | 1 | 0 = even phase, 1 = odd phase |

## Verification
The bench drives several kinds of input:
- A unit impulse followed by zeros, which moves one nonzero value through every history slot. This separates the coefficients from one another and confirms the odd phase picks the centre slot.
- A ramp and a pseudo-random stream, which check the pre-added pair sums and the rounding.
- Small negative odd values, which show whether the odd-phase shift floors.
- Sign patterns that line up with the coefficient signs, which drive the even phase into positive and negative clamping.

Output back-pressure of varying length, and input offered during processing, are mixed in. These expose lost holds and any sample taken early.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    typedef enum logic [1:0] {S_IDLE, S_MAC, S_EVEN, S_ODD} hbi_state_t;

    // distinct even-phase tap j (0 = outermost pair); sign alternates from the inner tap outward
    function automatic int coef_val(input int peak, input int nu, input int j);
        int d;
        int m;
        d = nu - 1 - j;
        m = peak >>> d;
        return (d % 2 == 0) ? m : -m;
    endfunction
endpackage

// File: rtl/hbi_ring.sv
module hbi_ring #(
    parameter int DW  = 16,
    parameter int NE  = 10,
    parameter int CTR = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          step,
    output logic [DW-1:0] lo_data,
    output logic [DW-1:0] hi_data,
    output logic [DW-1:0] ctr_data
);
    localparam int AW = $clog2(NE);

    logic [DW-1:0] mem [NE];
    logic [AW-1:0] wp, lo, hi, nwp, ctr_idx;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(NE - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? AW'(NE - 1) : p - 1'b1;
    endfunction

    assign nwp = ptr_inc(wp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            lo <= '0;
            hi <= '0;
            for (int i = 0; i < NE; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[nwp] <= wr_data;
            wp       <= nwp;
            lo       <= nwp;
            hi       <= ptr_inc(nwp);
        end else if (step) begin
            lo <= ptr_dec(lo);
            hi <= ptr_inc(hi);
        end
    end

    assign ctr_idx  = (wp >= AW'(CTR)) ? wp - AW'(CTR) : wp + AW'(NE - CTR);
    assign lo_data  = mem[lo];
    assign hi_data  = mem[hi];
    assign ctr_data = mem[ctr_idx];
endmodule

// File: rtl/hbi_coef.sv
module hbi_coef
    import hbi_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NU   = 5,
    parameter int PEAK = 20000,
    parameter int JW   = 3
) (
    input  logic [JW-1:0]        idx,
    output logic signed [CW-1:0] coef
);
    logic signed [CW-1:0] tbl [NU];

    for (genvar g = 0; g < NU; g++) begin : g_tap
        assign tbl[g] = CW'(coef_val(PEAK, NU, g));
    end

    assign coef = (int'(idx) < NU) ? tbl[idx] : '0;
endmodule

// File: rtl/hbi_mac.sv
module hbi_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NU   = 5,
    parameter int FRAC = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 issue,
    input  logic [DW-1:0]        a,
    input  logic [DW-1:0]        b,
    input  logic signed [CW-1:0] coef,
    output logic [DW-1:0]        result
);
    localparam int SW   = DW + 1;
    localparam int PW   = SW + CW;
    localparam int ACCW = PW + $clog2(NU);
    localparam logic signed [ACCW-1:0] HALF = ACCW'(1) << (FRAC - 1);
    localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 << (DW - 1)) - 1);
    localparam logic signed [ACCW-1:0] MINV = -MAXV - ACCW'(1);

    logic signed [SW-1:0]   pre;
    logic signed [CW-1:0]   c1;
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc, rnd, shr;
    logic                   v1, v2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre  <= '0;
            c1   <= '0;
            prod <= '0;
            acc  <= '0;
            v1   <= 1'b0;
            v2   <= 1'b0;
        end else begin
            v1   <= issue;
            v2   <= v1;
            pre  <= $signed({a[DW-1], a}) + $signed({b[DW-1], b});
            c1   <= coef;
            prod <= pre * c1;
            if (clr)     acc <= '0;
            else if (v2) acc <= acc + ACCW'(prod);
        end
    end

    always_comb begin
        rnd = acc + HALF;
        shr = rnd >>> FRAC;
        if (shr > MAXV)      result = {1'b0, {(DW-1){1'b1}}};
        else if (shr < MINV) result = {1'b1, {(DW-1){1'b0}}};
        else                 result = shr[DW-1:0];
    end
endmodule

// File: rtl/halfband_interp2.sv
module halfband_interp2
    import hbi_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int NTAPS = 19,
    parameter int PEAK  = 20000,
    parameter int FRAC  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_odd
);
    localparam int NE   = (NTAPS + 1) / 2;
    localparam int NU   = NE / 2;
    localparam int CTR  = NU - 1;
    localparam int CNTW = $clog2(NU + 2);

    hbi_state_t            state, state_nx;
    logic [CNTW-1:0]       cnt;
    logic                  accept, issue;
    logic [DW-1:0]         lo_data, hi_data, ctr_data, even_val;
    logic signed [CW-1:0]  coef;

    assign accept = (state == S_IDLE) && in_valid;
    assign issue  = (state == S_MAC) && (int'(cnt) < NU);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_valid)                   state_nx = S_MAC;
            S_MAC:   if (int'(cnt) == NU + 1)        state_nx = S_EVEN;
            S_EVEN:  if (out_ready)                  state_nx = S_ODD;
            S_ODD:   if (out_ready)                  state_nx = S_IDLE;
            default:                                 state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (accept)              cnt <= '0;
            else if (state == S_MAC) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        in_ready  = (state == S_IDLE);
        out_valid = (state == S_EVEN) || (state == S_ODD);
        out_odd   = (state == S_ODD);
        out_data  = (state == S_ODD) ? {ctr_data[DW-1], ctr_data[DW-1:1]} : even_val;
    end

    hbi_ring #(.DW(DW), .NE(NE), .CTR(CTR)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_data  (in_data),
        .step     (issue),
        .lo_data  (lo_data),
        .hi_data  (hi_data),
        .ctr_data (ctr_data)
    );

    hbi_coef #(.CW(CW), .NU(NU), .PEAK(PEAK), .JW(CNTW)) u_coef (
        .idx  (cnt),
        .coef (coef)
    );

    hbi_mac #(.DW(DW), .CW(CW), .NU(NU), .FRAC(FRAC)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .issue  (issue),
        .a      (lo_data),
        .b      (hi_data),
        .coef   (coef),
        .result (even_val)
    );
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk #(
    parameter int DW = 16,
    parameter int NU = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_odd
);
    logic [15:0] lat;

    always_ff @(posedge clk) begin
        if (!rst_n)                lat <= '0;
        else if (in_valid && in_ready) lat <= '0;
        else if (!out_valid)       lat <= lat + 1'b1;
    end

    // R2
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    even_then_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_odd) |=> (out_valid && out_odd));

    // R3
    odd_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_odd) |=> (in_ready && !out_valid));

    // R10
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_odd)));

    // R8
    even_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (int'(lat) == NU + 2));
endmodule

bind halfband_interp2 hbi_chk #(.DW(DW), .NU(NU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_odd   (out_odd)
);

// File: tb/halfband_interp2_test.sv
module halfband_interp2_test;
    localparam int NTAPS = 19;
    localparam int NE    = (NTAPS + 1) / 2;
    localparam int NU    = NE / 2;
    localparam int PEAK  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        out_odd;

    int checks = 0;
    int errors = 0;
    int hist [NE];
    bit done = 1'b0;

    always #4 clk = ~clk;

    halfband_interp2 #(.NTAPS(NTAPS), .PEAK(PEAK)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_odd(out_odd)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint cval(input int j);
        int d;
        d = NU - 1 - j;
        return (d % 2 == 0) ? longint'(PEAK >>> d) : -longint'(PEAK >>> d);
    endfunction

    function automatic int exp_even();
        longint a;
        longint r;
        a = 0;
        for (int j = 0; j < NU; j++) a += cval(j) * longint'(hist[j] + hist[NE-1-j]);
        r = (a + 16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic push(input int x, input int stall, input bit junk, input string tag);
        int lat;
        int ee;
        int eo;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready before offer", in_ready, 1);
        in_valid = 1'b1;
        in_data  = x[15:0];
        @(negedge clk);
        if (junk) in_data = 16'h7abc;
        else      in_valid = 1'b0;
        for (int k = NE - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        ee = exp_even();
        eo = hist[NU-1] >>> 1;
        lat = 0;
        while (!out_valid && lat < 100) begin
            chk(in_ready == 1'b0, "R2 busy", in_ready, 0);
            @(negedge clk);
            lat++;
        end
        chk(lat == NU + 2, "R8 latency", lat, NU + 2);
        chk(out_odd == 1'b0, "R3 even first", out_odd, 0);
        chk($signed(out_data) == ee, tag, $signed(out_data), ee);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(out_valid && !out_odd && $signed(out_data) == ee, "R10 even hold", $signed(out_data), ee);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid && out_odd, "R3 odd second", out_odd, 1);
        chk($signed(out_data) == eo, "R6 odd value", $signed(out_data), eo);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(out_valid && out_odd && $signed(out_data) == eo, "R10 odd hold", $signed(out_data), eo);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk(!out_valid && in_ready, "R3 two outputs then idle", out_valid, 0);
    endtask

    initial begin
        logic [31:0] lf;
        for (int k = 0; k < NE; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 after reset", out_valid, 0);

        // impulse through every slot: first output shows zero history, later ones each coefficient
        push(16384, 0, 1'b0, "R7 zero history");
        for (int i = 0; i < NE; i++) push(0, i % 2, 1'b0, "R5 coefficient");

        // ramp with backpressure
        for (int i = 0; i < 12; i++) push(-3000 + i * 517, i % 3, 1'b0, "R4 ramp");

        // odd negatives for the floor shift
        for (int i = 0; i < NE; i++) push(-1 - 2 * i, 0, 1'b1, "R4 small");

        // clamping, positive then negative
        for (int i = 0; i < NE; i++)
            push(((i % 5) % 2 == 0) ? 32767 : -32767, 0, 1'b0, (i == NE - 1) ? "R9 clamp high" : "R4 pattern");
        for (int i = 0; i < NE; i++)
            push(((i % 5) % 2 == 0) ? -32768 : 32767, 1, 1'b0, (i == NE - 1) ? "R9 clamp low" : "R4 pattern");

        // pseudo-random stream with input offered while busy
        lf = 32'h1bad5eed;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            push(int'($signed(lf[15:0])), i % 4, (i % 3 == 0), "R4 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule